// File: doc/BRIEF.md
# Per-Stream Coefficient Threshold Gate

This block de-noises a time-interleaved stream of wavelet coefficients that comes from many recording channels and several decomposition levels. Each coefficient is a signed-magnitude word (one sign bit above a magnitude field) with a channel tag and a band tag. For N decomposition levels each channel has N+1 bands, because the final level yields both an approximation band and a detail band. Each (channel, band) pair has its own threshold. The gate looks up that threshold, compares it with the coefficient magnitude, and then either forces the word to all zeros or forwards it unchanged.

The thresholds live in an internal register file. A write-only three-wire SPI slave (mode 0) loads them, and any entry may be rewritten while coefficients keep flowing. A plain mode pin selects one of two modes. In acquisition mode the gate applies the thresholds. In monitor mode every word passes through raw.

Coefficients enter and leave on valid/ready handshakes. A word transfers on a clock edge where valid and ready are both high. The output stage holds one word. The input is ready whenever that stage is empty or its word is leaving in the same cycle. While the output is stalled, the held word, its tags and its valid stay frozen, and no new word is taken in. Sustained throughput is one word per cycle when the downstream is always ready.

Top module: `thr_gate_top`

## Requirements
- R1: After reset the output valid is low, the input ready is high and every threshold is zero, so every coefficient passes unchanged until thresholds are programmed.
- R2: An SPI write frame is 17 bits, sampled on rising `spi_sclk` edges while `spi_cs_n` is low. The frame is an 8-bit register address followed by a 9-bit threshold, each sent most significant bit first. The address of channel c, band b is c*(levels+1)+b. The write takes effect once the 17th bit has been received. Each SCLK level must last at least three `clk` cycles.
- R3: A frame whose address is at or above channels*(levels+1) (160 at default sizes) changes no threshold.
- R4: A frame cut short by `spi_cs_n` rising before its 17th bit changes no threshold, and bits clocked after the 17th within the same select are ignored.
- R5: In acquisition mode (`mode_mon`=0), a coefficient whose 9-bit magnitude (bits 8:0) is strictly less than its stream's threshold leaves as the all-zero 10-bit word.
- R6: In acquisition mode, a coefficient whose magnitude is equal to or greater than the threshold leaves unchanged, sign bit (bit 9) included.
- R7: In monitor mode (`mode_mon`=1), every coefficient leaves unchanged whatever its threshold.
- R8: An accepted word appears at the output on the next clock edge, carrying the channel and band tags it was accepted with.
- R9: While `out_valid` is high and `out_ready` is low, the output word, its tags and `out_valid` hold, and `in_ready` is low.
- R10: A threshold rewrite during streaming is seen as a whole. Each coefficient is judged against either the complete old value or the complete new value, and once one coefficient has been judged against the new value, every later one is too.
- R11: A band tag at or above levels+1 is treated as threshold zero, so the word passes unchanged.
- R12: Writing one stream's threshold leaves every other stream's threshold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mon | input | 1 | 1 = monitor (raw bypass), 0 = acquisition (thresholding) |
| spi_sclk | input | 1 | SPI serial clock, mode 0, asynchronous to clk |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | SPI serial data into the block |
| in_valid | input | 1 | Input coefficient valid |
| in_ready | output | 1 | Block can accept a coefficient |
| in_data | input | 10 | Signed-magnitude coefficient: bit 9 sign, bits 8:0 magnitude |
| in_chan | input | 5 | Channel tag |
| in_band | input | 3 | Band tag, 0 to levels |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 10 | Gated coefficient |
| out_chan | output | 5 | Channel tag of the output word |
| out_band | output | 3 | Band tag of the output word |

## Verification
The bench builds the block with its defaults: 32 channels and 4 levels, which gives 5 bands per channel and 160 thresholds behind an 8-bit address. At these sizes the last valid entry (159), the first invalid addresses (160 and up) and the unused band codes 5 to 7 can all be reached from the ports. The bench exercises the equal-magnitude boundary, the serial frame edge cases (short and overlong), an output stall with a second word waiting, and a threshold rewrite while one stream is being pushed every other cycle.

// File: rtl/thr_gate_pkg.sv
package thr_gate_pkg;

  typedef enum logic {
    GATE_ACQ = 1'b0,
    GATE_MON = 1'b1
  } gate_mode_e;

endpackage

// File: rtl/thr_spi_rx.sv
module thr_spi_rx #(
  parameter int ADDR_W = 8,
  parameter int MAG_W  = 9,
  localparam int FRAME_W = ADDR_W + MAG_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [MAG_W-1:0]  wr_data
);

  logic [2:0]         sclk_s;
  logic [1:0]         cs_s;
  logic [1:0]         mosi_s;
  logic [FRAME_W-2:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               sclk_rise;
  logic               sel;
  logic [FRAME_W-1:0] frame_full;

  assign sclk_rise  = sclk_s[1] & ~sclk_s[2];
  assign sel        = ~cs_s[1];
  assign frame_full = {shreg, mosi_s[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= 2'b11;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      cs_s   <= {cs_s[0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (!sel) begin
      cnt <= '0;
    end else if (sclk_rise && (cnt < CNT_W'(FRAME_W))) begin
      shreg <= frame_full[FRAME_W-2:0];
      cnt   <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= sel && sclk_rise && (cnt == CNT_W'(FRAME_W - 1));
      if (sel && sclk_rise && (cnt == CNT_W'(FRAME_W - 1))) begin
        wr_addr <= frame_full[FRAME_W-1:MAG_W];
        wr_data <= frame_full[MAG_W-1:0];
      end
    end
  end

  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R4
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W));

  // R4
  deselect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt == '0) && !wr_en);

endmodule

// File: rtl/thr_bank.sv
module thr_bank #(
  parameter int DEPTH  = 160,
  parameter int ADDR_W = 8,
  parameter int MAG_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MAG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [MAG_W-1:0]  rd_thr
);

  logic [MAG_W-1:0] entry [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry[gi] <= '0;
      else if (wr_en && (int'(wr_addr) == gi))
        entry[gi] <= wr_data;
    end
  end

  always_comb begin
    rd_thr = '0;
    if (int'(rd_addr) < DEPTH)
      rd_thr = entry[rd_addr];
  end

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_addr) < DEPTH)) |=> entry[$past(wr_addr)] == $past(wr_data));

  // R1
  read_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) >= DEPTH) |-> (rd_thr == '0));

endmodule

// File: rtl/thr_gate_stage.sv
module thr_gate_stage #(
  parameter int MAG_W = 9,
  parameter int CH_W  = 5,
  parameter int BD_W  = 3,
  localparam int COEF_W = MAG_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  thr_gate_pkg::gate_mode_e mode,
  input  logic [MAG_W-1:0]        thr,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [COEF_W-1:0]       in_data,
  input  logic [CH_W-1:0]         in_chan,
  input  logic [BD_W-1:0]         in_band,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [COEF_W-1:0]       out_data,
  output logic [CH_W-1:0]         out_chan,
  output logic [BD_W-1:0]         out_band
);

  import thr_gate_pkg::*;

  logic accept;
  logic kill;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign kill     = (mode == GATE_ACQ) && (in_data[MAG_W-1:0] < thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
      out_band  <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= kill ? '0 : in_data;
        out_chan  <= in_chan;
        out_band  <= in_band;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)
                                  && $stable(out_chan) && $stable(out_band));

  // R8
  one_cycle_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid && (out_chan == $past(in_chan))
                               && (out_band == $past(in_band)));

  // R7
  monitor_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (mode == GATE_MON)) |=> out_data == $past(in_data));

  // R6
  pass_or_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data == $past(in_data)) || (out_data == '0));

endmodule

// File: rtl/thr_gate_top.sv
module thr_gate_top #(
  parameter int N_CHAN  = 32,
  parameter int N_LEVEL = 4,
  parameter int MAG_W   = 9,
  localparam int N_BAND = N_LEVEL + 1,
  localparam int DEPTH  = N_CHAN * N_BAND,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CH_W   = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
  localparam int BD_W   = $clog2(N_BAND),
  localparam int COEF_W = MAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_mon,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [COEF_W-1:0] in_data,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [BD_W-1:0]   in_band,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COEF_W-1:0] out_data,
  output logic [CH_W-1:0]   out_chan,
  output logic [BD_W-1:0]   out_band
);

  import thr_gate_pkg::*;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [MAG_W-1:0]  wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [MAG_W-1:0]  rd_thr;
  logic [MAG_W-1:0]  thr_eff;
  logic              band_ok;
  gate_mode_e        mode;

  assign mode    = mode_mon ? GATE_MON : GATE_ACQ;
  assign band_ok = int'(in_band) < N_BAND;
  assign rd_addr = ADDR_W'(int'(in_chan) * N_BAND + int'(in_band));
  assign thr_eff = band_ok ? rd_thr : '0;

  thr_spi_rx #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_spi (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  thr_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_thr  (rd_thr)
  );

  thr_gate_stage #(.MAG_W(MAG_W), .CH_W(CH_W), .BD_W(BD_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .thr       (thr_eff),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_chan   (in_chan),
    .in_band   (in_band),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_chan  (out_chan),
    .out_band  (out_band)
  );

  // R11
  band_oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !band_ok |-> (thr_eff == '0));

  // R9
  ready_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/thr_gate_top_test.sv
module thr_gate_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 5;
  localparam int FW = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_mon = 1'b0;
  logic       spi_sclk = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_data = '0;
  logic [4:0] in_chan = '0;
  logic [2:0] in_band = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_data;
  logic [4:0] out_chan;
  logic [2:0] out_band;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thr_gate_top uut (
    .clk(clk), .rst_n(rst_n), .mode_mon(mode_mon),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_chan(in_chan), .in_band(in_band),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .out_band(out_band)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic spi_write(input int addr, input int thr, input int nbits);
    logic [FW-1:0] frame;
    frame = {addr[7:0], thr[8:0]};
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < FW) ? frame[FW-1-i] : 1'b1;
      repeat (4) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (4) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // One transfer with an always-ready sink; checks latency and tags (R8).
  task automatic xfer(input int ch, input int bd, input logic [9:0] d,
                      input logic mon, output logic [9:0] got);
    @(negedge clk);
    mode_mon = mon; in_chan = ch[4:0]; in_band = bd[2:0]; in_data = d;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got = out_data;
    check(out_valid == 1'b1, "R8 out_valid one cycle after accept", int'(out_valid), 1);
    check(out_chan == ch[4:0] && out_band == bd[2:0], "R8 tags follow word",
          int'({out_chan, out_band}), int'({ch[4:0], bd[2:0]}));
  endtask

  task automatic expect_gate(input int ch, input int bd, input logic [9:0] d,
                             input logic mon, input logic [9:0] exp, input string req);
    logic [9:0] got;
    xfer(ch, bd, d, mon, got);
    check(got == exp, req, int'(got), int'(exp));
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 out_valid low after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready high after reset", int'(in_ready), 1);
    expect_gate(7, 3, 10'h201, 1'b0, 10'h201, "R1 zero threshold passes word");
    expect_gate(31, 4, 10'h001, 1'b0, 10'h001, "R1 zero threshold passes last stream");
  endtask

  task automatic t_boundary();
    spi_write(0 * NB + 0, 100, FW);
    expect_gate(0, 0, 10'd99, 1'b0, 10'd0, "R5 magnitude below threshold zeroed");
    expect_gate(0, 0, {1'b1, 9'd99}, 1'b0, 10'd0, "R5 negative below threshold zeroed");
    expect_gate(0, 0, {1'b1, 9'd100}, 1'b0, {1'b1, 9'd100}, "R6 equal magnitude kept with sign");
    expect_gate(0, 0, 10'd511, 1'b0, 10'd511, "R6 full magnitude kept");
  endtask

  task automatic t_monitor();
    expect_gate(0, 0, {1'b1, 9'd10}, 1'b1, {1'b1, 9'd10}, "R7 monitor bypasses threshold");
    expect_gate(0, 0, 10'd1, 1'b1, 10'd1, "R7 monitor small magnitude");
  endtask

  task automatic t_isolation();
    expect_gate(0, 1, 10'd1, 1'b0, 10'd1, "R12 neighbour band untouched");
    expect_gate(1, 0, 10'd1, 1'b0, 10'd1, "R12 neighbour channel untouched");
    spi_write(31 * NB + 4, 300, FW);
    expect_gate(31, 4, 10'd299, 1'b0, 10'd0, "R2 last address written");
    expect_gate(31, 4, 10'd300, 1'b0, 10'd300, "R2 last address equal passes");
    expect_gate(0, 0, 10'd99, 1'b0, 10'd0, "R12 first entry kept after other write");
  endtask

  task automatic t_range();
    spi_write(160, 511, FW);
    spi_write(255, 511, FW);
    expect_gate(31, 4, 10'd300, 1'b0, 10'd300, "R3 out-of-range write ignored (159)");
    expect_gate(0, 0, 10'd100, 1'b0, 10'd100, "R3 out-of-range write ignored (0)");
    expect_gate(0, 2, 10'd5, 1'b0, 10'd5, "R3 out-of-range write ignored (2)");
  endtask

  task automatic t_frames();
    spi_write(0 * NB + 2, 400, 10);
    expect_gate(0, 2, 10'd5, 1'b0, 10'd5, "R4 short frame discarded");
    spi_write(0 * NB + 3, 50, FW + 3);
    expect_gate(0, 3, 10'd49, 1'b0, 10'd0, "R4 overlong frame keeps first 17 bits");
    expect_gate(0, 3, 10'd50, 1'b0, 10'd50, "R4 overlong frame value exact");
  endtask

  task automatic t_band_oob();
    spi_write(1 * NB + 1, 200, FW);
    expect_gate(1, 1, 10'd10, 1'b0, 10'd0, "R2 channel 1 band 1 programmed");
    expect_gate(0, 6, 10'd10, 1'b0, 10'd10, "R11 band tag 6 passes");
    expect_gate(3, 7, 10'd1, 1'b0, 10'd1, "R11 band tag 7 passes");
  endtask

  task automatic t_stall();
    @(negedge clk);
    mode_mon = 1'b1; out_ready = 1'b0;
    in_chan = 5'd1; in_band = 3'd0; in_data = 10'h155; in_valid = 1'b1;
    @(negedge clk);
    in_chan = 5'd2; in_band = 3'd1; in_data = 10'h0AA; in_valid = 1'b1;
    check(in_ready == 1'b0, "R9 in_ready low while stalled", int'(in_ready), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid && out_data == 10'h155 && out_chan == 5'd1,
            "R9 held word stable", int'(out_data), 'h155);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == 10'h0AA && out_band == 3'd1,
          "R9 waiting word follows release", int'(out_data), 'h0AA);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 output drains", int'(out_valid), 0);
    mode_mon = 1'b0;
  endtask

  task automatic t_live_update();
    bit seen_new = 1'b0;
    fork
      spi_write(3 * NB + 2, 200, FW);
      begin
        for (int i = 0; i < 90; i++) begin
          logic [9:0] got;
          xfer(3, 2, 10'd50, 1'b0, got);
          if (got == 10'd0) seen_new = 1'b1;
          check((got == 10'd0) || (got == 10'd50 && !seen_new),
                "R10 old or new threshold, never back", int'(got), seen_new ? 0 : 50);
        end
      end
    join
    check(seen_new, "R10 new threshold reached", int'(seen_new), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boundary();
    t_monitor();
    t_isolation();
    t_range();
    t_frames();
    t_band_oob();
    t_stall();
    t_live_update();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule